// File: doc/BRIEF.md
# Byte-Wide Passive Configuration Loader

This block is the host side of a byte-parallel configuration load into a programmable target device. On a start command it pulses the target's active-low configuration reset. It then waits for the target's active-low status line to go low and come back high. After that it pulls image bytes from a ready/valid byte source and places each byte on an 8-bit bus. It also generates the configuration clock from the system clock, one byte per clock period.

The target raises its configuration-complete flag one byte before the end of the image. When the host sees that flag, it stops fetching bytes and issues a fixed number of further configuration clock pulses so that the target can start initialization. The load succeeds only when the target's initialization flag makes a low-to-high transition. The count of bytes sent does not decide success.

Each phase has its own timeout. A status drop during the load counts as a configuration error, and the host can restart automatically from the reset pulse. The byte source must restart the image from its first byte whenever the reset pulse is active. The target's three status inputs pass through synchronizers of `SYNC_STAGES` flops. `DIV` must exceed `SYNC_STAGES` so that the configuration-complete flag, raised at a rising clock edge, is seen before the next byte is fetched.

Top module: `cfg_host_seq`

## Requirements
- R1: A `start` pulse while idle drives `cfg_rst_n` low for exactly `pulse_len` system clock cycles. A value of 0 counts as 1. `busy` stays high from the cycle after `start` until the cycle that carries the outcome pulse.
- R2: No byte is fetched and `cfg_clk` stays low until `tgt_status_n` has been seen low and then high after the reset pulse. If either wait lasts longer than `STATUS_TMO` cycles, the load ends with `err_code` 1.
- R3: Bytes appear on `cfg_data` in source order, one byte per `cfg_clk` period. Each byte is held with `cfg_clk` low for `DIV` cycles and then high for `DIV` cycles. `cfg_data` changes only while `cfg_clk` is low and was low in the previous cycle.
- R4: Once `tgt_conf_done` has been seen high, the host accepts no more bytes. For a target that needs N bytes and raises the flag after byte N-1, exactly N-1 bytes are consumed from the source.
- R5: After `tgt_conf_done` has been seen, exactly `TRAIL_EDGES` extra `cfg_clk` pulses follow (default 2). The target therefore sees `TRAIL_EDGES`+1 falling edges after the flag rises. Afterwards `cfg_clk` stays low.
- R6: A low-to-high transition of `tgt_init_done` in the init phase gives a one-cycle `done_pulse`, with `err_code` 0 and `busy` low in that same cycle. A flag that is already high on entry to the init phase does not count.
- R7: If `tgt_status_n` drops during streaming or the extra clock pulses, the load fails with `err_code` 2. If `auto_retry` is high and fewer than `MAX_RETRY` restarts have been used, the host restarts from the reset pulse without an `err_pulse`. Otherwise it gives a one-cycle `err_pulse`.
- R8: If the source offers no byte for `SRC_TMO` cycles while `tgt_conf_done` is low, the load ends with `err_code` 3.
- R9: If no rising edge of `tgt_init_done` arrives within `INIT_TMO` cycles of the init phase, the load ends with `err_code` 4.
- R10: `tgt_ce_n` is always low. A `start` while busy is ignored, so no second reset pulse follows. After reset the block is idle: `cfg_rst_n` high, `cfg_clk` low, `src_ready` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a load (ignored while busy) |
| auto_retry | input | 1 | Restart after a status drop |
| pulse_len | input | 16 | Reset pulse length in cycles |
| src_data | input | 8 | Image byte from the source |
| src_valid | input | 1 | Source offers a byte |
| src_ready | output | 1 | Host takes the byte this cycle |
| cfg_rst_n | output | 1 | Active-low configuration reset to target |
| tgt_status_n | input | 1 | Target status, low = reset or error |
| tgt_conf_done | input | 1 | Target configuration-complete flag |
| tgt_init_done | input | 1 | Target initialization-complete flag |
| cfg_clk | output | 1 | Configuration clock |
| cfg_data | output | 8 | Configuration byte bus |
| tgt_ce_n | output | 1 | Chip enable, held low |
| busy | output | 1 | Load in progress |
| done_pulse | output | 1 | One-cycle success indication |
| err_pulse | output | 1 | One-cycle failure indication |
| err_code | output | 3 | 0 none, 1 status, 2 config error, 3 source starved, 4 init timeout |

## Verification
The hardest state to reach is a status drop partway through the image followed by an automatic restart. The bench target model pulls its status line low once, on a chosen byte. It then restores itself on the next reset pulse, and the bench source rewinds at the same moment, so the second attempt has to deliver the whole image in order. A second hard case is an initialization flag that is already high before the init phase. The model raises it together with the configuration-complete flag, and the host must then time out instead of reporting success.

// File: rtl/cfgh_pkg.sv
package cfgh_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PULSE,
        S_WLOW,
        S_WHIGH,
        S_LOAD,
        S_DLO,
        S_DHI,
        S_THI,
        S_TLO,
        S_INIT
    } seq_state_e;

    typedef enum logic [2:0] {
        ERR_NONE    = 3'd0,
        ERR_STATUS  = 3'd1,
        ERR_ABORT   = 3'd2,
        ERR_STARVE  = 3'd3,
        ERR_INIT    = 3'd4
    } cfg_err_e;

    typedef struct packed {
        logic status_n;
        logic conf_done;
        logic init_done;
    } tgt_pins_t;

    function automatic logic clk_high_in(seq_state_e s);
        return (s == S_DHI) || (s == S_THI);
    endfunction

    function automatic logic in_stream(seq_state_e s);
        return (s == S_LOAD) || (s == S_DLO) || (s == S_DHI) ||
               (s == S_THI)  || (s == S_TLO);
    endfunction

endpackage

// File: rtl/cfgh_sync.sv
module cfgh_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage[g] <= '0;
                else     stage[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage[g] <= '0;
                else     stage[g] <= stage[g-1];
            end
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/cfgh_timer.sv
module cfgh_timer #(
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic [CW-1:0] limit,
    output logic          expired
);
    logic [CW-1:0] cnt;
    logic [CW:0]   nxt;

    assign nxt     = {1'b0, cnt} + {{CW{1'b0}}, 1'b1};
    assign expired = nxt >= {1'b0, limit};

    always_ff @(posedge clk) begin
        if (rst || clr)    cnt <= '0;
        else if (!expired) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/cfg_host_seq.sv
module cfg_host_seq
    import cfgh_pkg::*;
#(
    parameter int DIV         = 4,
    parameter int SYNC_STAGES = 2,
    parameter int TRAIL_EDGES = 2,
    parameter int STATUS_TMO  = 100000,
    parameter int SRC_TMO     = 100000,
    parameter int INIT_TMO    = 1000000,
    parameter int MAX_RETRY   = 1,
    parameter int CW          = 24
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        auto_retry,
    input  logic [15:0] pulse_len,
    input  logic [7:0]  src_data,
    input  logic        src_valid,
    output logic        src_ready,
    output logic        cfg_rst_n,
    input  logic        tgt_status_n,
    input  logic        tgt_conf_done,
    input  logic        tgt_init_done,
    output logic        cfg_clk,
    output logic [7:0]  cfg_data,
    output logic        tgt_ce_n,
    output logic        busy,
    output logic        done_pulse,
    output logic        err_pulse,
    output logic [2:0]  err_code
);
    localparam int TRW = $clog2(TRAIL_EDGES + 1);
    localparam int RW  = $clog2(MAX_RETRY + 2);

    seq_state_e state_q, state_d;
    tgt_pins_t  pins_raw, pins_s;
    logic [2:0] pins_vec;
    logic       init_prev, init_rise;
    logic [CW-1:0] tm_limit;
    logic       tm_exp, tm_clr;
    logic [TRW-1:0] trail_q;
    logic [RW-1:0]  retry_q;
    logic       fail, retry_ok, finish_ok, accept, trail_step, start_ok;
    cfg_err_e   fail_code;
    cfg_err_e   code_q;
    logic [7:0] data_q;
    logic       clk_q, rst_n_q, done_q, errp_q;
    logic [15:0] plen;

    assign pins_raw.status_n  = tgt_status_n;
    assign pins_raw.conf_done = tgt_conf_done;
    assign pins_raw.init_done = tgt_init_done;

    cfgh_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pins_raw),
        .q   (pins_vec)
    );
    assign pins_s = tgt_pins_t'(pins_vec);

    cfgh_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clr     (tm_clr),
        .limit   (tm_limit),
        .expired (tm_exp)
    );

    assign plen      = (pulse_len == 16'd0) ? 16'd1 : pulse_len;
    assign init_rise = pins_s.init_done && !init_prev;
    assign src_ready = (state_q == S_LOAD) && pins_s.status_n && !pins_s.conf_done;
    assign accept    = src_ready && src_valid;
    assign start_ok  = (state_q == S_IDLE) && start;
    assign tm_clr    = (state_d != state_q);

    always_comb begin
        case (state_q)
            S_PULSE:         tm_limit = CW'(plen);
            S_WLOW, S_WHIGH: tm_limit = CW'(STATUS_TMO);
            S_LOAD:          tm_limit = CW'(SRC_TMO);
            S_INIT:          tm_limit = CW'(INIT_TMO);
            S_DLO, S_DHI, S_THI, S_TLO: tm_limit = CW'(DIV);
            default:         tm_limit = CW'(1);
        endcase
    end

    always_comb begin
        state_d    = state_q;
        fail       = 1'b0;
        fail_code  = ERR_NONE;
        finish_ok  = 1'b0;
        trail_step = 1'b0;
        if (in_stream(state_q) && !pins_s.status_n) begin
            fail      = 1'b1;
            fail_code = ERR_ABORT;
        end else begin
            case (state_q)
                S_IDLE:  if (start) state_d = S_PULSE;
                S_PULSE: if (tm_exp) state_d = S_WLOW;
                S_WLOW: begin
                    if (!pins_s.status_n) state_d = S_WHIGH;
                    else if (tm_exp) begin
                        fail = 1'b1; fail_code = ERR_STATUS;
                    end
                end
                S_WHIGH: begin
                    if (pins_s.status_n) state_d = S_LOAD;
                    else if (tm_exp) begin
                        fail = 1'b1; fail_code = ERR_STATUS;
                    end
                end
                S_LOAD: begin
                    if (pins_s.conf_done) state_d = S_THI;
                    else if (src_valid)   state_d = S_DLO;
                    else if (tm_exp) begin
                        fail = 1'b1; fail_code = ERR_STARVE;
                    end
                end
                S_DLO: if (tm_exp) state_d = S_DHI;
                S_DHI: if (tm_exp) state_d = S_LOAD;
                S_THI: if (tm_exp) state_d = S_TLO;
                S_TLO: begin
                    if (tm_exp) begin
                        trail_step = 1'b1;
                        state_d = (trail_q == TRW'(TRAIL_EDGES - 1)) ? S_INIT : S_THI;
                    end
                end
                S_INIT: begin
                    if (init_rise) begin
                        finish_ok = 1'b1;
                        state_d   = S_IDLE;
                    end else if (tm_exp) begin
                        fail = 1'b1; fail_code = ERR_INIT;
                    end
                end
                default: state_d = S_IDLE;
            endcase
        end
        retry_ok = (fail_code == ERR_ABORT) && auto_retry && (retry_q < RW'(MAX_RETRY));
        if (fail) state_d = retry_ok ? S_PULSE : S_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= S_IDLE;
            init_prev <= 1'b0;
            trail_q   <= '0;
            retry_q   <= '0;
            code_q    <= ERR_NONE;
            data_q    <= '0;
            clk_q     <= 1'b0;
            rst_n_q   <= 1'b1;
            done_q    <= 1'b0;
            errp_q    <= 1'b0;
        end else begin
            state_q   <= state_d;
            init_prev <= pins_s.init_done;
            clk_q     <= clk_high_in(state_d);
            rst_n_q   <= (state_d != S_PULSE);
            done_q    <= finish_ok;
            errp_q    <= fail && !retry_ok;
            if (accept) data_q <= src_data;
            if (state_q == S_LOAD)  trail_q <= '0;
            else if (trail_step)    trail_q <= trail_q + 1'b1;
            if (start_ok) begin
                retry_q <= '0;
                code_q  <= ERR_NONE;
            end else if (fail) begin
                if (retry_ok) retry_q <= retry_q + 1'b1;
                else          code_q  <= fail_code;
            end
        end
    end

    assign cfg_clk    = clk_q;
    assign cfg_rst_n  = rst_n_q;
    assign cfg_data   = data_q;
    assign tgt_ce_n   = 1'b0;
    assign busy       = (state_q != S_IDLE);
    assign done_pulse = done_q;
    assign err_pulse  = errp_q;
    assign err_code   = code_q;

    // R3: the byte bus moves only inside a low clock phase
    p_data_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_data) |-> (!cfg_clk && !$past(cfg_clk)));

    // R3: a fetch never overlaps a high clock phase
    p_ready_low_clk_r3: assert property (@(posedge clk) disable iff (rst)
        src_ready |-> !cfg_clk);

    // R2: no clock and no fetch before the status release
    p_quiet_before_release_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_PULSE || state_q == S_WLOW || state_q == S_WHIGH)
            |-> (!cfg_clk && !src_ready));

    // R1: the reset pulse only occurs inside a load
    p_pulse_in_load_r1: assert property (@(posedge clk) disable iff (rst)
        !cfg_rst_n |-> busy);

    // R6: outcomes are exclusive and end the load
    p_outcome_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(done_pulse && err_pulse));
    p_outcome_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (done_pulse || err_pulse) |-> !busy);
    p_busy_end_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (done_pulse || err_pulse));
    p_done_code_r6: assert property (@(posedge clk) disable iff (rst)
        done_pulse |-> (err_code == 3'd0));

    // R7: a failure always carries a cause
    p_err_code_r7: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> (err_code != 3'd0));

    // R5: the clock is parked low once the init phase is reached
    p_clk_parked_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_INIT) |-> !cfg_clk);

endmodule

// File: tb/cfg_host_seq_test.sv
module cfg_host_seq_test;
    localparam int DIV   = 4;
    localparam int TRAIL = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0, auto_retry = 1'b0;
    logic [15:0] pulse_len = 16'd4;
    logic [7:0] src_data = 8'd0;
    logic src_valid = 1'b0;
    logic src_ready, cfg_rst_n, cfg_clk, tgt_ce_n, busy, done_pulse, err_pulse;
    logic [7:0] cfg_data;
    logic [2:0] err_code;
    logic tgt_status_n = 1'b1, tgt_conf_done = 1'b0, tgt_init_done = 1'b0;

    always #10 clk = ~clk;

    cfg_host_seq #(
        .DIV(DIV), .SYNC_STAGES(2), .TRAIL_EDGES(TRAIL),
        .STATUS_TMO(200), .SRC_TMO(100), .INIT_TMO(300), .MAX_RETRY(1), .CW(24)
    ) uut (
        .clk(clk), .rst(rst), .start(start), .auto_retry(auto_retry),
        .pulse_len(pulse_len), .src_data(src_data), .src_valid(src_valid),
        .src_ready(src_ready), .cfg_rst_n(cfg_rst_n), .tgt_status_n(tgt_status_n),
        .tgt_conf_done(tgt_conf_done), .tgt_init_done(tgt_init_done),
        .cfg_clk(cfg_clk), .cfg_data(cfg_data), .tgt_ce_n(tgt_ce_n), .busy(busy),
        .done_pulse(done_pulse), .err_pulse(err_pulse), .err_code(err_code)
    );

    int total = 0, bad = 0;

    // target and source model settings
    int img_len = 8, src_avail = 64, drop_at = -1;
    bit never_low = 0, hang_rel = 0, no_init = 0, early_init = 0;
    logic [7:0] src_mem [64];
    logic [7:0] cap [64];

    // observations
    int cap_cnt = 0, acc_cnt = 0, rises_after = 0, falls_after = 0;
    int early_rises = 0, unstable = 0, cfg_pulses = 0, pulse_w = 0;
    int done_seen = 0, errp_seen = 0, ce_bad = 0;
    bit released = 0, dropped = 0, acc_pend = 0;
    int rel_cnt = 0, init_cnt = -1, src_idx = 0;
    logic clk_prev = 0, rst_n_prev = 1;
    logic [7:0] data_prev = 0;

    function automatic int exp_bytes(int len); return len - 1; endfunction
    function automatic int exp_width(int p);   return (p == 0) ? 1 : p; endfunction
    function automatic int exp_falls();        return TRAIL + 1; endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (done_pulse) done_seen++;
            if (err_pulse)  errp_seen++;
            if (tgt_ce_n !== 1'b0) ce_bad++;
            if (cfg_data != data_prev && (cfg_clk || clk_prev)) unstable++;
            if (acc_pend) begin
                acc_cnt++;
                src_idx++;
            end
            if (!cfg_rst_n) begin
                if (rst_n_prev) begin
                    cfg_pulses++;
                    if (cfg_pulses == 1) pulse_w = 0;
                end
                if (cfg_pulses == 1) pulse_w++;
                tgt_status_n = never_low;
                tgt_conf_done = 0; tgt_init_done = 0;
                cap_cnt = 0; acc_cnt = 0; rises_after = 0; falls_after = 0;
                released = 0; rel_cnt = 0; init_cnt = -1; src_idx = 0;
            end else if (!released && !never_low) begin
                rel_cnt++;
                if (rel_cnt == 5 && !hang_rel) begin
                    tgt_status_n = 1; released = 1;
                end
            end
            if (cfg_clk && !clk_prev) begin
                if (!released) early_rises++;
                if (!tgt_conf_done) begin
                    cap[cap_cnt] = cfg_data;
                    cap_cnt++;
                    if (cap_cnt == img_len - 1) begin
                        tgt_conf_done = 1;
                        if (early_init) tgt_init_done = 1;
                    end
                    if (cap_cnt == drop_at && !dropped) begin
                        tgt_status_n = 0; dropped = 1;
                    end
                end else rises_after++;
            end
            if (!cfg_clk && clk_prev && tgt_conf_done) begin
                falls_after++;
                if (falls_after == 2 && !no_init && !tgt_init_done) init_cnt = 20;
            end
            if (init_cnt > 0) begin
                init_cnt--;
                if (init_cnt == 0) begin tgt_init_done = 1; init_cnt = -1; end
            end
            clk_prev = cfg_clk; rst_n_prev = cfg_rst_n; data_prev = cfg_data;
            if (src_idx < src_avail && ($urandom % 4) != 0) begin
                src_valid = 1; src_data = src_mem[src_idx];
            end else begin
                src_valid = 0; src_data = $urandom;
            end
            acc_pend = src_valid && src_ready;
        end
    end

    task automatic setup(input int len, input int avail);
        img_len = len; src_avail = avail; drop_at = -1;
        never_low = 0; hang_rel = 0; no_init = 0; early_init = 0;
        dropped = 0; auto_retry = 0;
        cfg_pulses = 0; done_seen = 0; errp_seen = 0; unstable = 0; early_rises = 0;
        for (int i = 0; i < 64; i++) src_mem[i] = $urandom;
    endtask

    task automatic run_load(input int pl, input bit poke_busy, output int code, output bit ok);
        int n = 0;
        bit poked = 0;
        pulse_len = pl[15:0];
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        while (!(done_pulse || err_pulse) && n < 20000) begin
            @(negedge clk);
            n++;
            if (poke_busy && !poked && cap_cnt == 3) begin
                start = 1; poked = 1;
                @(negedge clk); start = 0;
            end
        end
        code = err_code;
        ok = done_pulse;
        check(n < 20000, "R6 outcome reached", n, 20000);
        repeat (3) @(negedge clk);
    endtask

    task automatic check_good(input int len, input int pl, input int code, input bit ok);
        int mism = 0;
        check(ok, "R6 done pulse", ok, 1);
        check(code == 0, "R6 err_code", code, 0);
        check(done_seen == 1 && errp_seen == 0, "R6 single outcome", done_seen, 1);
        check(cap_cnt == exp_bytes(len), "R4 bytes captured", cap_cnt, exp_bytes(len));
        check(acc_cnt == exp_bytes(len), "R4 bytes consumed", acc_cnt, exp_bytes(len));
        for (int i = 0; i < cap_cnt; i++) if (cap[i] != src_mem[i]) mism++;
        check(mism == 0, "R3 byte order", mism, 0);
        check(unstable == 0, "R3 data stable", unstable, 0);
        check(rises_after == TRAIL, "R5 trailing pulses", rises_after, TRAIL);
        check(falls_after == exp_falls(), "R5 trailing falls", falls_after, exp_falls());
        check(early_rises == 0, "R2 clock before release", early_rises, 0);
        check(pulse_w == exp_width(pl), "R1 reset width", pulse_w, exp_width(pl));
        check(!busy && !cfg_clk, "R5 clock parked", cfg_clk, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog R6 actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int code;
        bit ok;
        void'($urandom(32'h5eed_0c0f));
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R10 reset state
        check(!busy && cfg_rst_n && !cfg_clk && !src_ready && !tgt_ce_n && !done_pulse && !err_pulse,
              "R10 reset state", busy, 0);

        // R1 R3 R4 R5 R6: random images and pulse lengths
        for (int k = 0; k < 6; k++) begin
            int len = 8 + ($urandom % 33);
            int pl = 1 + ($urandom % 20);
            setup(len, 64);
            run_load(pl, 0, code, ok);
            check_good(len, pl, code, ok);
        end

        // R1 zero pulse length, R4 minimal image
        setup(2, 64);
        run_load(0, 0, code, ok);
        check_good(2, 0, code, ok);

        // R10 start while busy is ignored
        setup(20, 64);
        run_load(6, 1, code, ok);
        check(cfg_pulses == 1, "R10 start ignored while busy", cfg_pulses, 1);
        check(ok && ce_bad == 0, "R10 chip enable low", ce_bad, 0);

        // R2 status never asserted
        setup(16, 64); never_low = 1;
        run_load(5, 0, code, ok);
        check(code == 1 && errp_seen == 1, "R2 status never low", code, 1);
        check(cap_cnt == 0 && early_rises == 0, "R2 no bytes sent", cap_cnt, 0);
        never_low = 0;

        // R2 status never released
        setup(16, 64); hang_rel = 1;
        run_load(5, 0, code, ok);
        check(code == 1, "R2 release timeout", code, 1);
        check(cap_cnt == 0, "R2 no bytes before release", cap_cnt, 0);
        hang_rel = 0;

        // R7 drop without retry
        setup(24, 64); drop_at = 7;
        run_load(4, 0, code, ok);
        check(code == 2 && errp_seen == 1 && !ok, "R7 abort code", code, 2);

        // R7 drop with automatic restart
        setup(24, 64); drop_at = 9; auto_retry = 1;
        run_load(4, 0, code, ok);
        check(cfg_pulses == 2, "R7 restart pulse count", cfg_pulses, 2);
        check(errp_seen == 0, "R7 no err pulse on retry", errp_seen, 0);
        check_good(24, 4, code, ok);
        auto_retry = 0;

        // R8 source starves
        setup(30, 12);
        run_load(3, 0, code, ok);
        check(code == 3 && errp_seen == 1, "R8 starve code", code, 3);
        check(cap_cnt == 12, "R8 bytes before starve", cap_cnt, 12);

        // R9 init never rises
        setup(10, 64); no_init = 1;
        run_load(3, 0, code, ok);
        check(code == 4 && !ok, "R9 init timeout", code, 4);
        no_init = 0;

        // R6 R9 init flag already high: no rising edge, so timeout
        setup(10, 64); early_init = 1;
        run_load(3, 0, code, ok);
        check(code == 4 && done_seen == 0, "R6 stale init flag ignored", code, 4);
        early_init = 0;

        // R6 a clean load after errors still succeeds
        setup(12, 64);
        run_load(2, 0, code, ok);
        check_good(12, 2, code, ok);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule